// File: doc/BRIEF.md
# PCM Mixer Output Queue

This block is the last stage of a PCM audio mixer. Mixed samples arrive one channel at a time, and a fixed number of channels make up one frame. The block writes each sample into a first-in first-out store, and a downstream receiver drains that store one entry per read. A single 32-bit control word, loaded by a write strobe, holds three settings: a fill threshold, a silence bit and an enable bit.

The block raises a level-sensitive trigger while the number of stored entries is above the threshold. Silencing changes the stored value of each sample to zero, but every sample still takes up one entry. A change to the silence bit takes effect only at the first channel of a frame, so no frame is ever partly silenced. While the block is disabled, incoming samples are discarded and the frame position returns to the start. Writes into a full store and reads from an empty store are refused. Each refusal sets a sticky flag that stays set until a clear pulse.

Top module: `pcm_dest_stage`

## Requirements
- R1: After reset, the control word is all zero: the block is disabled, not silenced, and the threshold is 0. The level is 0, and `trig`, `ovf` and `unf` are all low.
- R2: When `cfg_we` is high, the control word is loaded from `cfg_wdata`. Bits 5:0 form the threshold (0..63), bit 16 is the silence bit and bit 18 is the enable bit. The new values govern samples from the next cycle on.
- R3: While the enable bit is 0, a sample offered on `smp_valid` is not stored and `level` does not change. The frame position also returns to channel 0, so the first sample after the block is enabled again is treated as the first channel of a frame.
- R4: Stored samples come out in arrival order. `rd_data` shows the entry one cycle after the cycle in which `rd_en` was high.
- R5: `trig` is high exactly when the stored count is strictly greater than the threshold. It reflects a push or pop in the cycle after that push or pop.
- R6: A silenced sample is stored as zero and still takes one entry, raising `level` by one exactly as an unsilenced sample does.
- R7: The silence bit is sampled when channel 0 of a frame is accepted, and that value applies to all CHANS channels of the frame. The channel position wraps after CHANS accepted samples.
- R8: A sample accepted while the store holds DEPTH entries is dropped. `level` stays at DEPTH and `ovf` goes high and stays high until a `clr_ovf` pulse.
- R9: A read while the store is empty leaves `rd_data` unchanged and sets `unf`. `unf` stays high until a `clr_unf` pulse.
- R10: `level` reports the stored count, from 0 up to and including DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word value |
| smp_valid | input | 1 | Mixed sample present this cycle |
| smp_data | input | DW | Mixed sample value |
| rd_en | input | 1 | Receiver read request |
| clr_ovf | input | 1 | Clear pulse for the overflow flag |
| clr_unf | input | 1 | Clear pulse for the underflow flag |
| rd_data | output | DW | Last entry read |
| level | output | $clog2(DEPTH)+1 | Stored entry count |
| trig | output | 1 | Count above threshold |
| ovf | output | 1 | Sticky overflow flag |
| unf | output | 1 | Sticky underflow flag |

## Verification
The bench builds the block with DEPTH=64, DW=16 and CHANS=3. With a depth of 64, the top threshold value of 63 meets a completely full store, so the trigger can be checked at its last boundary and the overflow refusal can be reached. Three channels per frame leave two channels after the first, and this is where a silence change made mid-frame must be ignored. The odd frame length also places the disable-and-enable test in the middle of a frame.

// File: rtl/pcmdst_pkg.sv
package pcmdst_pkg;
    localparam int THR_W    = 6;
    localparam int THR_LSB  = 0;
    localparam int MUTE_BIT = 16;
    localparam int ACT_BIT  = 18;
endpackage

// File: rtl/pcmdst_frame.sv
module pcmdst_frame
    import pcmdst_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CHANS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [31:0]      cfg_wdata,
    input  logic             smp_valid,
    input  logic [DW-1:0]    smp_data,
    output logic [THR_W-1:0] thr,
    output logic             push,
    output logic [DW-1:0]    push_data
);
    localparam int CW = (CHANS > 1) ? $clog2(CHANS) : 1;
    localparam logic [CW-1:0] LAST = CW'(CHANS - 1);

    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic             mute;
        logic             active;
        logic [CW-1:0]    chan;
        logic             fmute;
    } frame_st_t;

    frame_st_t s_d, s_q;
    logic accept, first, eff_mute;

    always_comb begin
        s_d      = s_q;
        accept   = smp_valid && s_q.active;
        first    = (s_q.chan == '0);
        eff_mute = first ? s_q.mute : s_q.fmute;
        if (accept) begin
            if (first) s_d.fmute = s_q.mute;
            s_d.chan = (s_q.chan == LAST) ? '0 : s_q.chan + 1'b1;
        end
        if (!s_q.active) s_d.chan = '0;
        if (cfg_we) begin
            s_d.thr    = cfg_wdata[THR_LSB +: THR_W];
            s_d.mute   = cfg_wdata[MUTE_BIT];
            s_d.active = cfg_wdata[ACT_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign thr       = s_q.thr;
    assign push      = accept;
    assign push_data = eff_mute ? '0 : smp_data;

    // R3: a disabled cycle leaves the frame position at channel 0
    p_idle_chan_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.active |=> (s_q.chan == '0));
    // R7: the frame's silence value holds through its later channels
    p_frame_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && s_q.chan != '0) |=> $stable(s_q.fmute));
endmodule

// File: rtl/pcmdst_store.sv
module pcmdst_store #(
    parameter int DW    = 16,
    parameter int DEPTH = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [DW-1:0]   push_data,
    input  logic            pop,
    input  logic            clr_ovf,
    input  logic            clr_unf,
    output logic [DW-1:0]   rd_data,
    output logic [$clog2(DEPTH):0] level,
    output logic            ovf,
    output logic            unf
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [AW:0]   cnt;
        logic [DW-1:0] rdata;
        logic          ovf;
        logic          unf;
    } store_st_t;

    store_st_t s_d, s_q;
    logic [DW-1:0] mem [DEPTH];
    logic full, empty, wr_ok, rd_ok;

    always_comb begin
        s_d   = s_q;
        full  = (s_q.cnt == FULL);
        empty = (s_q.cnt == '0);
        wr_ok = push && !full;
        rd_ok = pop && !empty;
        if (clr_ovf) s_d.ovf = 1'b0;
        if (clr_unf) s_d.unf = 1'b0;
        if (push && full) s_d.ovf = 1'b1;
        if (pop && empty) s_d.unf = 1'b1;
        if (wr_ok) s_d.wptr = s_q.wptr + 1'b1;
        if (rd_ok) begin
            s_d.rptr  = s_q.rptr + 1'b1;
            s_d.rdata = mem[s_q.rptr];
        end
        case ({wr_ok, rd_ok})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[s_q.wptr] <= push_data;
    end

    assign rd_data = s_q.rdata;
    assign level   = s_q.cnt;
    assign ovf     = s_q.ovf;
    assign unf     = s_q.unf;

    // R8: a push into a full store is refused
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (s_q.cnt == FULL));
    // R8: overflow flag is sticky
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ovf && !clr_ovf) |=> s_q.ovf);
    // R9: empty read raises the flag and keeps the output
    p_unf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> (s_q.unf && $stable(s_q.rdata)));
    // R10: count never exceeds the depth
    p_level_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= FULL);
endmodule

// File: rtl/pcm_dest_stage.sv
module pcm_dest_stage
    import pcmdst_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 64,
    parameter int CHANS = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [31:0]            cfg_wdata,
    input  logic                   smp_valid,
    input  logic [DW-1:0]          smp_data,
    input  logic                   rd_en,
    input  logic                   clr_ovf,
    input  logic                   clr_unf,
    output logic [DW-1:0]          rd_data,
    output logic [$clog2(DEPTH):0] level,
    output logic                   trig,
    output logic                   ovf,
    output logic                   unf
);
    logic [THR_W-1:0] thr;
    logic             push;
    logic [DW-1:0]    push_data;

    pcmdst_frame #(.DW(DW), .CHANS(CHANS)) u_frame (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .thr(thr), .push(push), .push_data(push_data)
    );

    pcmdst_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(rd_en), .clr_ovf(clr_ovf), .clr_unf(clr_unf),
        .rd_data(rd_data), .level(level), .ovf(ovf), .unf(unf)
    );

    assign trig = 32'(level) > 32'(thr);

    // R5: trigger never high with an empty store
    p_trig_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> !trig);
endmodule

// File: tb/pcm_dest_stage_bench.sv
module pcm_dest_stage_bench;
    localparam int DW = 16, DEPTH = 64, CHANS = 3;

    logic clk = 0, rst_n = 0;
    logic cfg_we = 0, smp_valid = 0, rd_en = 0, clr_ovf = 0, clr_unf = 0;
    logic [31:0] cfg_wdata = '0;
    logic [DW-1:0] smp_data = '0;
    logic [DW-1:0] rd_data;
    logic [6:0] level;
    logic trig, ovf, unf;

    pcm_dest_stage #(.DW(DW), .DEPTH(DEPTH), .CHANS(CHANS)) u_pcm_dest_stage (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .smp_valid(smp_valid), .smp_data(smp_data), .rd_en(rd_en),
        .clr_ovf(clr_ovf), .clr_unf(clr_unf), .rd_data(rd_data),
        .level(level), .trig(trig), .ovf(ovf), .unf(unf)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0;
    logic [DW-1:0] sb[$];
    int m_thr = 0, m_chan = 0, m_cnt = 0;
    bit m_mute = 0, m_act = 0, m_fmute = 0;
    logic [DW-1:0] m_last = '0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cfg(int t, bit mu, bit ac);
        @(negedge clk);
        cfg_we = 1;
        cfg_wdata = '0;
        cfg_wdata[5:0] = 6'(t);
        cfg_wdata[16] = mu;
        cfg_wdata[18] = ac;
        @(negedge clk);
        cfg_we = 0;
        m_thr = t; m_mute = mu; m_act = ac;
        if (!ac) m_chan = 0;
    endtask

    // driver: offers one sample and queues what the store should hold
    task automatic put(logic [DW-1:0] d);
        bit em;
        @(negedge clk);
        smp_valid = 1;
        smp_data = d;
        if (m_act) begin
            em = (m_chan == 0) ? m_mute : m_fmute;
            if (m_chan == 0) m_fmute = m_mute;
            if (m_cnt < DEPTH) begin
                sb.push_back(em ? '0 : d);
                m_cnt++;
            end
            m_chan = (m_chan + 1) % CHANS;
        end
        @(negedge clk);
        smp_valid = 0;
    endtask

    // monitor: reads one entry and compares with the queue head
    task automatic get();
        logic [DW-1:0] exp;
        @(negedge clk);
        rd_en = 1;
        @(negedge clk);
        rd_en = 0;
        if (m_cnt > 0) begin
            exp = sb.pop_front();
            m_cnt--;
            m_last = exp;
            chk(rd_data == exp, "R4", "read order/value (R6 R7 zeros)", int'(rd_data), int'(exp));
        end else begin
            chk(rd_data == m_last, "R9", "empty read holds data", int'(rd_data), int'(m_last));
            chk(unf == 1'b1, "R9", "underflow set", int'(unf), 1);
        end
    endtask

    task automatic lvl(string req);
        chk(int'(level) == m_cnt, "R10", "level", int'(level), m_cnt);
        chk(trig == (m_cnt > m_thr), req, "trigger vs threshold", int'(trig), int'(m_cnt > m_thr));
    endtask

    initial begin
        #(200000 * 10);
        chk(0, "WDOG", "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(level == 0, "R1", "reset level", int'(level), 0);
        chk(!trig && !ovf && !unf, "R1", "reset flags", int'({trig, ovf, unf}), 0);
        // R3 disabled: samples dropped
        put(16'h0a); put(16'h0b);
        chk(level == 0, "R3", "disabled drops samples", int'(level), 0);
        // R2 enable, threshold 0
        cfg(0, 0, 1);
        put(16'h11); lvl("R5");
        cfg(2, 0, 1);
        put(16'h12); lvl("R5");
        put(16'h13); lvl("R5");
        // R7 silence change mid-frame is deferred
        put(16'h21);
        cfg(2, 1, 1);
        put(16'h22); put(16'h23);
        // R6 silenced frame still occupies entries
        put(16'h31); put(16'h32); put(16'h33); lvl("R6");
        cfg(2, 0, 1);
        put(16'h41); put(16'h51);
        // R3 disable mid-frame restarts the frame
        cfg(2, 1, 0);
        put(16'h55);
        cfg(2, 1, 1);
        put(16'h61);
        cfg(2, 0, 1);
        put(16'h62); put(16'h63); lvl("R3");
        while (m_cnt > 0) get();
        lvl("R5");
        // R9 empty read
        get();
        @(negedge clk); clr_unf = 1; @(negedge clk); clr_unf = 0;
        chk(unf == 0, "R9", "underflow cleared", int'(unf), 0);
        // R5 boundary at 63 and R8 overflow
        cfg(63, 0, 1);
        for (int i = 0; i < DEPTH - 1; i++) put(16'(16'h100 + i));
        lvl("R5");
        put(16'h1ff); lvl("R5");
        chk(ovf == 0, "R8", "no overflow when just full", int'(ovf), 0);
        put(16'h2aa);
        chk(level == 7'(DEPTH), "R8", "level held at depth", int'(level), DEPTH);
        chk(ovf == 1, "R8", "overflow set", int'(ovf), 1);
        @(negedge clk);
        chk(ovf == 1, "R8", "overflow sticky", int'(ovf), 1);
        clr_ovf = 1; @(negedge clk); clr_ovf = 0;
        chk(ovf == 0, "R8", "overflow cleared", int'(ovf), 0);
        while (m_cnt > 0) get();
        lvl("R10");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule